// File: doc/BRIEF.md
# ECC Error Capture and Logging Unit

This block sits beside the data array of a cache and watches the per-read results of its single-error-correct / double-error-detect checker. A half cache line is read as four 128-bit lanes. Each lane carries a 10-bit check code. For every read the checker presents the following on a result bus:

- the lane syndromes,
- one correctable-error bit and one uncorrectable-error bit per lane,
- the half-line index and the set number.

While checking is switched on, the block keeps two sticky flags, one for correctable errors and one for uncorrectable errors. It also keeps one failure log: the index, the set, a lane mask and the four syndromes. Uncorrectable errors take precedence over correctable ones. It raises a registered interrupt, gated separately for each error class.

With checking switched off, a diagnostic mode can be enabled. In that mode a load marked as coming from the diagnostic requester stores the raw check bits of one software-chosen half of the line in the syndrome fields. This lets software read the stored codes directly.

Software reaches everything through a small word-addressed read/write port. Reads are combinational. Writes take effect at the clock edge.

Top module: `ecc_err_log`

## Requirements
- R1: While the check-enable bit (control bit 0) is 0, lane results set neither flag and leave the failure log and the syndromes untouched.
- R2: The correctable flag (control bit 5) and the uncorrectable flag (control bit 6) are sticky. Writing 1 to either bit at address 0 clears that flag, and writing 0 leaves it unchanged. A new event in the same cycle as a clear keeps the flag set. Control bits 4:0 are stored from the write data.
- R3: A correctable event with neither flag set logs the index, the set, the mask of correctable lanes and all four syndromes. A later correctable event leaves the log unchanged while either flag is set.
- R4: An uncorrectable event with the uncorrectable flag clear overwrites the log, even if the log holds correctable information, and stores the mask of uncorrectable lanes. A second uncorrectable event while the flag is set leaves the log unchanged.
- R5: When correctable and uncorrectable lanes arrive in the same read, the log takes the uncorrectable lane mask and both flags are set.
- R6: `ecc_irq` is a register. It goes high one cycle after (correctable flag AND control bit 1) OR (uncorrectable flag AND control bit 2) becomes true, and low one cycle after that term becomes false.
- R7: With the check-enable bit 0 and the diagnostic bit (control bit 3) 1, a valid read with `res_diag_req` high stores raw check codes into the four syndrome fields. With control bit 4 at 0, lanes 0 to 3 of `res_chk` are stored. With control bit 4 at 1, lanes 4 to 7 are stored. Such a read never changes the index, the set, the mask or the flags, and a read without `res_diag_req` changes nothing.
- R8: After reset, every register reads 0 and `ecc_irq` is 0. The register map is:
  - Address 1: index in bits 10:0 (bit 0 selects the half line, the rest is the line index), set in bits 13:11, lane mask in bits 17:14.
  - Address 2: lane 0 syndrome in bits 9:0, lane 1 syndrome in bits 19:10.
  - Address 3: lane 2 syndrome in bits 9:0, lane 3 syndrome in bits 19:10.
  - Addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result bus carries a completed read |
| res_sec | input | 4 | Per-lane correctable error |
| res_ded | input | 4 | Per-lane uncorrectable error |
| res_syn | input | 40 | Four 10-bit lane syndromes, lane 0 in the low bits |
| res_index | input | 11 | Half-line index of the read |
| res_set | input | 3 | Set number of the read |
| res_diag_req | input | 1 | Read issued by the diagnostic requester |
| res_chk | input | 80 | Raw check codes of all eight lanes of the line, lane 0 in the low bits |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| ecc_irq | output | 1 | Gated error interrupt |

## Verification
The bench targets three cases in which the log must keep what it holds:

- A correctable event that arrives while a log is already held. A design that ignores the hold would replace the first failing address with the latest one.
- An uncorrectable event that lands on a correctable log. A design with the priority reversed would keep the correctable index and mask.
- A combined correctable and uncorrectable read. A design that picks the wrong mask would report the correctable lanes.

Clearing a flag in the same cycle as a new event is exercised, because a design where the clear wins would drop the event. Diagnostic captures are run with both half-select values, and with the requester bit low, to catch a swapped half or an accidental update of the index.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_LOG  = 1;
  localparam int ADDR_SYN  = 2;

  localparam int B_ECC_ON  = 0;
  localparam int B_SEC_IE  = 1;
  localparam int B_DED_IE  = 2;
  localparam int B_DIAG_ON = 3;
  localparam int B_HALF    = 4;
  localparam int B_SEC_FLG = 5;
  localparam int B_DED_FLG = 6;

  // Log write decision: an uncorrectable event wins unless one is already held;
  // a correctable event only fills an empty log.
  function automatic logic log_wins(logic sec_ev, logic ded_ev,
                                    logic sec_held, logic ded_held);
    if (ded_ev) return !ded_held;
    return sec_ev && !sec_held && !ded_held;
  endfunction

  function automatic logic irq_term(logic sec_f, logic sec_ie,
                                    logic ded_f, logic ded_ie);
    return (sec_f && sec_ie) || (ded_f && ded_ie);
  endfunction
endpackage

// File: rtl/ecc_evt_decode.sv
module ecc_evt_decode #(
  parameter int LANES = 4
) (
  input  logic             res_valid,
  input  logic             ecc_on,
  input  logic             diag_on,
  input  logic             diag_req,
  input  logic [LANES-1:0] sec_lanes,
  input  logic [LANES-1:0] ded_lanes,
  input  logic             sec_held,
  input  logic             ded_held,
  output logic             sec_ev,
  output logic             ded_ev,
  output logic             log_take,
  output logic [LANES-1:0] log_mask,
  output logic             diag_take
);
  import ecc_log_pkg::*;

  always_comb begin
    sec_ev    = res_valid && ecc_on && (|sec_lanes);
    ded_ev    = res_valid && ecc_on && (|ded_lanes);
    log_take  = log_wins(sec_ev, ded_ev, sec_held, ded_held);
    log_mask  = ded_ev ? ded_lanes : sec_lanes;
    diag_take = res_valid && !ecc_on && diag_on && diag_req;
  end
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
  parameter int LANES = 4,
  parameter int SYN_W = 10,
  parameter int IDX_W = 11,
  parameter int SET_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     log_take,
  input  logic                     diag_take,
  input  logic                     half_sel,
  input  logic [LANES-1:0]         log_mask,
  input  logic [IDX_W-1:0]         index,
  input  logic [SET_W-1:0]         set_no,
  input  logic [LANES*SYN_W-1:0]   syn,
  input  logic [2*LANES*SYN_W-1:0] chk,
  output logic [IDX_W-1:0]         idx_q,
  output logic [SET_W-1:0]         set_q,
  output logic [LANES-1:0]         mask_q,
  output logic [LANES*SYN_W-1:0]   syn_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      set_q  <= '0;
      mask_q <= '0;
    end else if (log_take) begin
      idx_q  <= index;
      set_q  <= set_no;
      mask_q <= log_mask;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SYN_W-1:0] raw_sel;
    assign raw_sel = half_sel ? chk[(LANES+i)*SYN_W +: SYN_W]
                              : chk[i*SYN_W +: SYN_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         syn_q[i*SYN_W +: SYN_W] <= '0;
      else if (log_take)  syn_q[i*SYN_W +: SYN_W] <= syn[i*SYN_W +: SYN_W];
      else if (diag_take) syn_q[i*SYN_W +: SYN_W] <= raw_sel;
    end
  end

  // R3: without a log write the failing address fields hold
  p_log_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !log_take |=> ($stable(idx_q) && $stable(set_q) && $stable(mask_q)));

  // R7: a diagnostic capture never disturbs the failing address
  p_diag_keeps_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    diag_take |=> $stable(idx_q));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int LANES  = 4,
  parameter int SYN_W  = 10,
  parameter int IDX_W  = 11,
  parameter int SET_W  = 3,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     res_valid,
  input  logic [LANES-1:0]         res_sec,
  input  logic [LANES-1:0]         res_ded,
  input  logic [LANES*SYN_W-1:0]   res_syn,
  input  logic [IDX_W-1:0]         res_index,
  input  logic [SET_W-1:0]         res_set,
  input  logic                     res_diag_req,
  input  logic [2*LANES*SYN_W-1:0] res_chk,
  input  logic                     cfg_wr,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [DATA_W-1:0]        cfg_rdata,
  output logic                     ecc_irq
);
  import ecc_log_pkg::*;

  localparam int CFG_W    = B_HALF + 1;
  localparam int SYN_REGS = LANES / 2;

  logic [CFG_W-1:0] cfg_q;
  logic sec_flag, ded_flag;
  logic ecc_on, sec_ie, ded_ie, diag_on, half_sel;
  logic ctrl_wr, clr_sec, clr_ded;
  logic sec_ev, ded_ev, log_take, diag_take;
  logic [LANES-1:0] log_mask, mask_q;
  logic [IDX_W-1:0] idx_q;
  logic [SET_W-1:0] set_q;
  logic [LANES*SYN_W-1:0] syn_q;
  logic unused_wdata;

  assign ecc_on   = cfg_q[B_ECC_ON];
  assign sec_ie   = cfg_q[B_SEC_IE];
  assign ded_ie   = cfg_q[B_DED_IE];
  assign diag_on  = cfg_q[B_DIAG_ON];
  assign half_sel = cfg_q[B_HALF];

  assign ctrl_wr  = cfg_wr && (cfg_addr == ADDR_W'(ADDR_CTRL));
  assign clr_sec  = ctrl_wr && cfg_wdata[B_SEC_FLG];
  assign clr_ded  = ctrl_wr && cfg_wdata[B_DED_FLG];
  assign unused_wdata = ^cfg_wdata[DATA_W-1:B_DED_FLG+1];

  ecc_evt_decode #(.LANES(LANES)) u_decode (
    .res_valid (res_valid),
    .ecc_on    (ecc_on),
    .diag_on   (diag_on),
    .diag_req  (res_diag_req),
    .sec_lanes (res_sec),
    .ded_lanes (res_ded),
    .sec_held  (sec_flag),
    .ded_held  (ded_flag),
    .sec_ev    (sec_ev),
    .ded_ev    (ded_ev),
    .log_take  (log_take),
    .log_mask  (log_mask),
    .diag_take (diag_take)
  );

  ecc_capture #(.LANES(LANES), .SYN_W(SYN_W), .IDX_W(IDX_W), .SET_W(SET_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_take  (log_take),
    .diag_take (diag_take),
    .half_sel  (half_sel),
    .log_mask  (log_mask),
    .index     (res_index),
    .set_no    (res_set),
    .syn       (res_syn),
    .chk       (res_chk),
    .idx_q     (idx_q),
    .set_q     (set_q),
    .mask_q    (mask_q),
    .syn_q     (syn_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      sec_flag <= 1'b0;
      ded_flag <= 1'b0;
      ecc_irq  <= 1'b0;
    end else begin
      if (ctrl_wr) cfg_q <= cfg_wdata[CFG_W-1:0];
      sec_flag <= (sec_flag && !clr_sec) || sec_ev;
      ded_flag <= (ded_flag && !clr_ded) || ded_ev;
      ecc_irq  <= irq_term(sec_flag, sec_ie, ded_flag, ded_ie);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == ADDR_W'(ADDR_CTRL)) begin
      cfg_rdata[CFG_W-1:0]  = cfg_q;
      cfg_rdata[B_SEC_FLG]  = sec_flag;
      cfg_rdata[B_DED_FLG]  = ded_flag;
    end else if (cfg_addr == ADDR_W'(ADDR_LOG)) begin
      cfg_rdata[IDX_W+SET_W+LANES-1:0] = {mask_q, set_q, idx_q};
    end else begin
      for (int k = 0; k < SYN_REGS; k++) begin
        if (cfg_addr == ADDR_W'(ADDR_SYN + k))
          cfg_rdata[2*SYN_W-1:0] = syn_q[2*k*SYN_W +: 2*SYN_W];
      end
    end
  end

  // R1: with checking off no flag can appear
  p_off_no_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_on && !sec_flag && !ded_flag) |=> (!sec_flag && !ded_flag));

  // R2: the correctable flag stays until cleared
  p_sticky_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_flag && !clr_sec) |=> sec_flag);

  // R4: a first uncorrectable event records its own lane mask
  p_ded_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ecc_on && (|res_ded) && !ded_flag) |=> (mask_q == $past(res_ded)));

  // R6: no flag, no interrupt on the next cycle
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_flag && !ded_flag) |=> !ecc_irq);
endmodule

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [3:0]  res_sec = '0, res_ded = '0;
  logic [39:0] res_syn = '0;
  logic [10:0] res_index = '0;
  logic [2:0]  res_set = '0;
  logic        res_diag_req = 1'b0;
  logic [79:0] res_chk = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ecc_irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  ecc_err_log dut (.*);

  // behavioural reference model
  int m_cfg = 0, m_sec = 0, m_ded = 0, m_irq = 0;
  int m_idx = 0, m_set = 0, m_mask = 0;
  int m_syn[4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_sec = 0; m_ded = 0; m_irq = 0;
      m_idx = 0; m_set = 0; m_mask = 0;
      foreach (m_syn[i]) m_syn[i] = 0;
    end else begin
      int on, sev, dev, nsec, nded;
      on  = m_cfg & 1;
      sev = (res_valid && on && res_sec != 0) ? 1 : 0;
      dev = (res_valid && on && res_ded != 0) ? 1 : 0;
      m_irq = ((m_sec && (m_cfg & 2)) || (m_ded && (m_cfg & 4))) ? 1 : 0;
      nsec = m_sec; nded = m_ded;
      if (cfg_wr && cfg_addr == 0) begin
        if (cfg_wdata[5]) nsec = 0;
        if (cfg_wdata[6]) nded = 0;
      end
      if (sev) nsec = 1;
      if (dev) nded = 1;
      if ((dev && !m_ded) || (sev && !dev && !m_sec && !m_ded)) begin
        m_idx = res_index; m_set = res_set;
        m_mask = dev ? res_ded : res_sec;
        for (int i = 0; i < 4; i++) m_syn[i] = res_syn[i*10 +: 10];
      end else if (res_valid && !on && (m_cfg & 8) && res_diag_req) begin
        for (int i = 0; i < 4; i++)
          m_syn[i] = (m_cfg & 16) ? res_chk[(4+i)*10 +: 10] : res_chk[i*10 +: 10];
      end
      m_sec = nsec; m_ded = nded;
      if (cfg_wr && cfg_addr == 0) m_cfg = cfg_wdata[4:0];
    end
  end

  function automatic int model_read(int a);
    case (a)
      0: return m_cfg | (m_sec << 5) | (m_ded << 6);
      1: return m_idx | (m_set << 11) | (m_mask << 14);
      2: return m_syn[0] | (m_syn[1] << 10);
      3: return m_syn[2] | (m_syn[3] << 10);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      case (cfg_addr)
        3'd0: tag = "R2 ctrl";
        3'd1: tag = "R3/R4 log";
        3'd2, 3'd3: tag = "R7 syndromes";
        default: tag = "R8 unmapped";
      endcase
      check("R6 irq", int'(ecc_irq), m_irq);
      check(tag, int'(cfg_rdata), model_read(int'(cfg_addr)));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    res_valid = 0; res_sec = 0; res_ded = 0; res_diag_req = 0;
    cfg_wr = 0; cfg_wdata = 0;
  endtask

  task automatic wr_ctrl(int v);
    tick(); idle(); cfg_wr = 1; cfg_addr = 0; cfg_wdata = v;
    tick(); idle();
  endtask

  task automatic read_chk(int a, int exp, string tag);
    tick(); idle(); cfg_addr = 3'(a);
    @(negedge clk);
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic event_rd(int sec, int ded, int idx, int st, logic [39:0] syn);
    tick(); idle();
    res_valid = 1; res_sec = 4'(sec); res_ded = 4'(ded);
    res_index = 11'(idx); res_set = 3'(st); res_syn = syn;
    tick(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    read_chk(0, 0, "R8 reset ctrl");
    read_chk(1, 0, "R8 reset log");
    check("R8 reset irq", int'(ecc_irq), 0);
    // R1 checking off: errors ignored
    event_rd(4'h3, 4'h4, 11'h55, 2, 40'hFFFFFFFFFF);
    read_chk(0, 0, "R1 no flags when off");
    read_chk(1, 0, "R1 log untouched when off");
    read_chk(2, 0, "R1 syndrome untouched when off");
    // R3 first correctable logs
    wr_ctrl(32'h07);
    event_rd(4'h4, 0, 11'h2A5, 5, {10'h155, 10'h3FF, 10'h022, 10'h011});
    read_chk(0, 32'h27, "R2 sec flag set");
    read_chk(1, 32'h12AA5, "R3 first sec log");
    read_chk(2, 32'h8811, "R3 syndromes lanes 0/1");
    read_chk(3, 32'h557FF, "R3 syndromes lanes 2/3");
    check("R6 irq after sec", int'(ecc_irq), 1);
    // R3 second correctable does not overwrite
    event_rd(4'h1, 0, 11'h100, 1, 40'h0);
    read_chk(1, 32'h12AA5, "R3 held log kept");
    // R4 uncorrectable overwrites
    event_rd(0, 4'hA, 11'h7FF, 7, {4{10'h0AB}});
    read_chk(1, 32'h2BFFF, "R4 ded overwrite");
    read_chk(0, 32'h67, "R2 both flags");
    event_rd(0, 4'h1, 0, 0, 40'h0);
    read_chk(1, 32'h2BFFF, "R4 second ded kept");
    // R2 clear
    wr_ctrl(32'h67);
    read_chk(0, 32'h07, "R2 w1c clear");
    read_chk(0, 32'h07, "R6 settle");
    check("R6 irq low after clear", int'(ecc_irq), 0);
    // R6 gate off
    wr_ctrl(32'h05);
    event_rd(4'h2, 0, 11'h10, 0, 40'h0);
    read_chk(0, 32'h25, "R6 flag set but gated");
    check("R6 irq gated", int'(ecc_irq), 0);
    wr_ctrl(32'h25);
    // R5 simultaneous
    event_rd(4'h1, 4'h8, 11'h003, 2, 40'h0);
    read_chk(1, 32'h21003, "R5 ded mask wins");
    read_chk(0, 32'h65, "R5 both flags");
    // R7 diagnostic capture
    wr_ctrl(32'h60);
    wr_ctrl(32'h18);
    tick(); idle();
    for (int k = 0; k < 8; k++) res_chk[k*10 +: 10] = 10'(32'h100 + k);
    res_valid = 1; res_diag_req = 1; res_index = 11'h7; res_set = 1;
    tick(); idle();
    read_chk(2, 32'h41504, "R7 diag upper half 0/1");
    read_chk(3, 32'h41D06, "R7 diag upper half 2/3");
    read_chk(1, 32'h21003, "R7 log untouched by diag");
    wr_ctrl(32'h08);
    tick(); idle(); res_valid = 1; res_diag_req = 1; tick(); idle();
    read_chk(2, 32'h40500, "R7 diag lower half");
    wr_ctrl(32'h18);
    tick(); idle(); res_valid = 1; res_diag_req = 0; tick(); idle();
    read_chk(2, 32'h40500, "R7 no capture without requester");
    read_chk(5, 0, "R8 unmapped reads 0");
    // same-cycle set and clear: set wins (R2)
    wr_ctrl(32'h07);
    tick(); idle(); res_valid = 1; res_sec = 4'h2; cfg_wr = 1; cfg_addr = 0; cfg_wdata = 32'h27;
    tick(); idle();
    read_chk(0, 32'h27, "R2 set beats clear");
    // random phase, model compared each cycle
    for (int c = 0; c < 6000; c++) begin
      tick(); idle();
      cfg_addr = 3'(c % 8);
      if ($urandom_range(0, 9) == 0) begin
        cfg_wr = 1; cfg_addr = 0;
        cfg_wdata = $urandom & 32'h7E;
        cfg_wdata[0] = ($urandom_range(0, 3) != 0);
      end
      res_valid = $urandom_range(0, 1);
      for (int l = 0; l < 4; l++) begin
        res_sec[l] = ($urandom_range(0, 7) == 0);
        res_ded[l] = ($urandom_range(0, 15) == 0);
      end
      res_syn = {$urandom, $urandom};
      res_chk = {$urandom, $urandom, $urandom};
      res_index = 11'($urandom); res_set = 3'($urandom);
      res_diag_req = $urandom_range(0, 1);
    end
    tick(); idle();
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule